// File: doc/BRIEF.md
# Command Stream Header Decoder

The decoder walks a command list held in a word-wide memory and turns it into a stream of method writes. The list is defined by a start address and a length in 32-bit words. Each header word names a method, a subchannel, an argument count and a submission mode. The mode sets how the method number moves across the data words that follow the header. One mode carries its value inside the header and has no data words.

Each emitted write carries the method number, the subchannel, a 32-bit value and the number of parameters still to come for that header. Writes leave on a valid/ready handshake. While a write waits for acceptance, the decoder issues no memory reads. The memory port has a fixed latency of one cycle: data for a read issued in one cycle is expected on `mem_rdata` in the next.

Top module: `cmd_hdr_decoder`

## Requirements
- R1: A header with mode code 1 (increasing), or legacy code 0, sends its i-th data word (i from 0) to method+i, with the method wrapping at 13 bits.
- R2: A header with mode code 3 (non-increasing), or legacy code 2, sends every data word to the header's method.
- R3: A header with mode code 5 (increase-once) sends its first data word to the method and every later data word to method+1.
- R4: A header with mode code 4 (inline) produces one write whose value is header bits 28:16, zero-extended, with remaining count 0. It uses no data words, and the next word is read as a header.
- R5: The i-th write of a header reports remaining = count − i − 1, so the last write of a header reports 0.
- R6: A header word holds the method in bits 12:0, the subchannel in bits 15:13, the argument count in bits 28:16 and the mode in bits 31:29. Every write carries its header's subchannel.
- R7: Reads start at the start address and advance by one word for each header and each data word. Reading stops once the list length is used up, even inside a header's arguments. A zero length reads nothing.
- R8: While `wr_valid` is high and `wr_ready` is low, all write outputs stay unchanged and `mem_rd` stays low.
- R9: `done` is high for exactly one cycle per list. That cycle is the one right after the last write is accepted, or right after the last read when the list produces no write. `busy` falls after it.
- R10: Mode codes 6 and 7, and mode 5 with a zero count, raise `err` for one cycle and produce no write. The next word is then read as a header.
- R11: A mode 0 to 3 header with a zero count produces no write and no error. The next word is read as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a list; taken only while idle |
| start_addr | input | AW | Word address of the first list word |
| list_len | input | LW | List length in words |
| mem_rd | output | 1 | Read request |
| mem_addr | output | AW | Read word address |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| wr_valid | output | 1 | Method write present |
| wr_ready | input | 1 | Method write accepted when high with valid |
| wr_method | output | 13 | Method number |
| wr_subch | output | 3 | Subchannel |
| wr_data | output | 32 | Write value |
| wr_remain | output | 13 | Parameters still to come for this header |
| busy | output | 1 | A list is in progress |
| done | output | 1 | One-cycle end-of-list pulse |
| err | output | 1 | One-cycle bad-header pulse |

## Verification
The directed tests target the method-step rules and the points where they are easy to get wrong. These are: the second and third words of an increase-once header, where a design that keeps incrementing would write method+2; a method near the 13-bit top, which must wrap; and the inline header, where a design that treated the count field as a word count would swallow the following header. Error headers and zero-count headers are mixed into one list, and the test counts both the writes and the reads. A design that consumed arguments after a bad mode, or flagged an error on an empty increasing header, would therefore be caught. A pseudo-random ready pattern checks that no write is lost or duplicated under stalls. Truncated and zero-length lists check that the read count stops at the length and that `done` still arrives one cycle after the final accept.

// File: rtl/cmd_hdr_decoder.sv
module cmd_hdr_decoder #(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] list_len,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_rdata,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [12:0]   wr_method,
  output logic [2:0]    wr_subch,
  output logic [31:0]   wr_data,
  output logic [12:0]   wr_remain,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam int MW = 13;
  localparam logic [2:0] M_INC_OLD = 3'd0, M_INC = 3'd1, M_SAME_OLD = 3'd2,
                         M_SAME = 3'd3, M_IMM = 3'd4, M_ONCE = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_CAP, S_EMIT} state_t;
  state_t state;

  logic [AW-1:0] ptr;
  logic [LW-1:0] left;
  logic          in_args;
  logic [2:0]    mode_q;
  logic [MW-1:0] base_q, cnt_q, idx_q;
  logic [2:0]    sub_q;

  wire [MW-1:0] h_method = mem_rdata[12:0];
  wire [2:0]    h_sub    = mem_rdata[15:13];
  wire [MW-1:0] h_cnt    = mem_rdata[28:16];
  wire [2:0]    h_mode   = mem_rdata[31:29];

  wire h_stream = (h_mode == M_INC_OLD) || (h_mode == M_INC) ||
                  (h_mode == M_SAME_OLD) || (h_mode == M_SAME) || (h_mode == M_ONCE);
  wire h_bad    = (h_mode > M_ONCE) || (h_mode == M_ONCE && h_cnt == '0);

  logic [MW-1:0] step;
  always_comb begin
    case (mode_q)
      M_INC_OLD, M_INC: step = idx_q;
      M_ONCE:           step = (idx_q != '0) ? MW'(1) : '0;
      default:          step = '0;
    endcase
  end

  assign wr_valid = (state == S_EMIT);
  assign mem_rd   = (state == S_RD) && (left != '0);
  assign mem_addr = ptr;
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_RD) && (left == '0);
  assign err      = (state == S_CAP) && !in_args && h_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ptr       <= '0;
      left      <= '0;
      in_args   <= 1'b0;
      mode_q    <= '0;
      base_q    <= '0;
      cnt_q     <= '0;
      idx_q     <= '0;
      sub_q     <= '0;
      wr_method <= '0;
      wr_subch  <= '0;
      wr_data   <= '0;
      wr_remain <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          ptr     <= start_addr;
          left    <= list_len;
          in_args <= 1'b0;
          state   <= S_RD;
        end
        S_RD: begin
          if (left == '0) state <= S_IDLE;
          else begin
            ptr   <= ptr + AW'(1);
            left  <= left - LW'(1);
            state <= S_CAP;
          end
        end
        S_CAP: begin
          if (in_args) begin
            wr_method <= base_q + step;
            wr_subch  <= sub_q;
            wr_data   <= mem_rdata;
            wr_remain <= cnt_q - idx_q - MW'(1);
            state     <= S_EMIT;
          end else if (h_mode == M_IMM) begin
            wr_method <= h_method;
            wr_subch  <= h_sub;
            wr_data   <= {19'd0, h_cnt};
            wr_remain <= '0;
            state     <= S_EMIT;
          end else begin
            mode_q  <= h_mode;
            base_q  <= h_method;
            sub_q   <= h_sub;
            cnt_q   <= h_cnt;
            idx_q   <= '0;
            in_args <= h_stream && !h_bad && (h_cnt != '0);
            state   <= S_RD;
          end
        end
        S_EMIT: if (wr_ready) begin
          state <= S_RD;
          if (in_args) begin
            idx_q <= idx_q + MW'(1);
            if (idx_q + MW'(1) == cnt_q) in_args <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_hdr_decoder_chk.sv
module cmd_hdr_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [12:0] wr_method,
  input logic [2:0]  wr_subch,
  input logic [31:0] wr_data,
  input logic [12:0] wr_remain,
  input logic        busy,
  input logic        done,
  input logic        err
);
  a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_method) && $stable(wr_subch)
                              && $stable(wr_data) && $stable(wr_remain));

  a_r8_no_read_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !mem_rd);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r10_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wr_valid && busy);
endmodule

bind cmd_hdr_decoder cmd_hdr_decoder_chk u_chk (.*);

// File: tb/cmd_hdr_decoder_bench.sv
`timescale 1ns/1ps
module cmd_hdr_decoder_bench;
  logic clk = 0, rst_n = 0, start = 0, wr_ready = 1;
  logic [15:0] start_addr = 0, list_len = 0;
  logic mem_rd, wr_valid, busy, done, err;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata = 0, wr_data;
  logic [12:0] wr_method, wr_remain;
  logic [2:0] wr_subch;

  always #2 clk = ~clk;

  cmd_hdr_decoder u_cmd_hdr_decoder (.*);

  logic [31:0] mem [0:63];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];

  int total = 0, bad = 0;
  int nw, nr, ne, nd, stall_bad, cyc = 0, acc_cyc, done_cyc;
  logic [60:0] wlog [0:31];
  logic [15:0] rlog [0:31];
  logic bp_on = 0;
  logic [7:0] lfsr = 8'h5A;

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wr_ready <= bp_on ? lfsr[0] : 1'b1;
  end

  always @(posedge clk) begin
    if (wr_valid && wr_ready) begin
      if (nw < 32) wlog[nw] = {wr_method, wr_subch, wr_data, wr_remain};
      nw++; acc_cyc = cyc;
    end
    if (mem_rd) begin
      if (nr < 32) rlog[nr] = mem_addr;
      nr++;
      if (wr_valid) stall_bad++;
    end
    if (err) ne++;
    if (done) begin nd++; done_cyc = cyc; end
    cyc++;
  end

  function automatic logic [31:0] hdr(int mode, int cnt, int sub, int meth);
    return {mode[2:0], cnt[12:0], sub[2:0], meth[12:0]};
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic ew(string req, int k, int m, int s, logic [31:0] d, int r);
    logic [60:0] e;
    e = {m[12:0], s[2:0], d, r[12:0]};
    check(req, $sformatf("write %0d", k), (k < nw) ? {3'b0, wlog[k]} : 64'hBAD, {3'b0, e});
  endtask

  task automatic reads(string req, int a0, int n);
    logic ok = (nr == n);
    for (int i = 0; i < n && i < 32; i++) if (rlog[i] != 16'(a0 + i)) ok = 0;
    check(req, "read addresses/count", {63'd0, ok} | (64'(nr) << 8), 64'(n) << 8 | 64'd1);
  endtask

  task automatic run(int a, int len);
    nw = 0; nr = 0; ne = 0; nd = 0; stall_bad = 0;
    @(negedge clk); start = 1; start_addr = 16'(a); list_len = 16'(len);
    @(negedge clk); start = 0;
    for (int t = 0; t < 3000 && nd == 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R9", "done count", 64'(nd), 64'd1);
  endtask

  task automatic t_reset;
    check("R9", "reset outputs", {60'd0, wr_valid, mem_rd, busy, done}, 64'd0);
  endtask

  task automatic t_increasing;
    mem[0] = hdr(1, 3, 2, 'h100); mem[1] = 'hA; mem[2] = 'hB; mem[3] = 'hC;
    run(0, 4);
    check("R1", "write count", 64'(nw), 64'd3);
    ew("R1", 0, 'h100, 2, 'hA, 2);
    ew("R5", 1, 'h101, 2, 'hB, 1);
    ew("R1", 2, 'h102, 2, 'hC, 0);
    reads("R7", 0, 4);
    check("R9", "done one cycle after last accept", 64'(done_cyc), 64'(acc_cyc + 1));
  endtask

  task automatic t_legacy_wrap;
    mem[4] = hdr(0, 2, 4, 'h1FFF); mem[5] = 'h11; mem[6] = 'h22;
    run(4, 3);
    ew("R1", 0, 'h1FFF, 4, 'h11, 1);
    ew("R1", 1, 'h0000, 4, 'h22, 0);
  endtask

  task automatic t_same;
    mem[8] = hdr(3, 2, 1, 'h20); mem[9] = 'h1; mem[10] = 'h2;
    mem[11] = hdr(2, 1, 5, 'h30); mem[12] = 'h3;
    run(8, 5);
    check("R2", "write count", 64'(nw), 64'd3);
    ew("R2", 0, 'h20, 1, 'h1, 1);
    ew("R2", 1, 'h20, 1, 'h2, 0);
    ew("R2", 2, 'h30, 5, 'h3, 0);
    reads("R7", 8, 5);
  endtask

  task automatic t_once;
    mem[14] = hdr(5, 3, 6, 'h40); mem[15] = 'h7; mem[16] = 'h8; mem[17] = 'h9;
    run(14, 4);
    ew("R3", 0, 'h40, 6, 'h7, 2);
    ew("R3", 1, 'h41, 6, 'h8, 1);
    ew("R3", 2, 'h41, 6, 'h9, 0);
  endtask

  task automatic t_errors;
    mem[20] = hdr(6, 1, 0, 1); mem[21] = hdr(5, 0, 0, 2); mem[22] = hdr(1, 0, 0, 3);
    mem[23] = hdr(7, 0, 0, 4); mem[24] = hdr(4, 'h12, 0, 7);
    run(20, 5);
    check("R10", "error pulses", 64'(ne), 64'd3);
    check("R11", "write count", 64'(nw), 64'd1);
    ew("R10", 0, 7, 0, 'h12, 0);
    reads("R7", 20, 5);
  endtask

  task automatic t_inline;
    mem[40] = hdr(4, 'h1ABC, 7, 'h55); mem[41] = hdr(1, 1, 0, 'h60); mem[42] = 'hDEAD;
    run(40, 3);
    check("R4", "write count", 64'(nw), 64'd2);
    ew("R4", 0, 'h55, 7, 'h1ABC, 0);
    ew("R6", 1, 'h60, 0, 'hDEAD, 0);
  endtask

  task automatic t_backpressure;
    mem[44] = hdr(1, 5, 3, 'h200);
    for (int i = 0; i < 5; i++) mem[45 + i] = 32'h1000 + i;
    bp_on = 1;
    run(44, 6);
    bp_on = 0;
    check("R8", "write count", 64'(nw), 64'd5);
    for (int i = 0; i < 5; i++) ew("R8", i, 'h200 + i, 3, 32'h1000 + i, 4 - i);
    check("R8", "reads while pending", 64'(stall_bad), 64'd0);
    check("R9", "done after last accept", 64'(done_cyc), 64'(acc_cyc + 1));
  endtask

  task automatic t_truncated;
    mem[30] = hdr(1, 4, 1, 'h10); mem[31] = 'h5; mem[32] = 'h6;
    run(30, 3);
    check("R7", "write count", 64'(nw), 64'd2);
    ew("R7", 1, 'h11, 1, 'h6, 2);
    reads("R7", 30, 3);
  endtask

  task automatic t_empty;
    run(50, 0);
    check("R7", "zero length writes+reads", 64'(nw + nr), 64'd0);
    check("R9", "idle after done", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_increasing();
    t_legacy_wrap();
    t_same();
    t_once();
    t_errors();
    t_inline();
    t_backpressure();
    t_truncated();
    t_empty();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule